// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit sits beside the decode stage of a 32-bit RISC pipeline that has one branch delay slot. For each instruction presented with `in_valid`, it takes the instruction word, the address of that instruction and the two source register values. It decides whether a conditional branch or a jump is taken and produces the next fetch address. All results are registered and appear one clock after the instruction is presented.

The unit builds the target in one of three ways. A taken branch uses a PC-relative offset. A not-taken branch uses the address after the delay slot. A jump splices a 26-bit index into the 256 MiB region of the delay-slot address. The and-link forms request a write of the return address into register 31. That request takes priority over a write offered on the shared write port in the same cycle.

A two-state machine tracks the delay slot. In `ST_IDLE` no slot is pending. In `ST_SLOT` the instruction that follows a branch is expected. The transitions are as follows:
- `ST_IDLE` goes to `ST_SLOT` when any valid branch or jump is presented.
- `ST_SLOT` goes to `ST_IDLE` when a valid non-branch instruction is presented.
- `ST_SLOT` stays in `ST_SLOT` when a valid branch is presented. That branch is flagged as an error but still resolved.
- Cycles without `in_valid` hold the state.

Top module: `brj_resolve_unit`

## Requirements
- R1: A taken conditional branch gives `res_valid=1`, `res_taken=1` and `res_target = pc + 4 + (sign-extended instr[15:0] << 2)` one cycle after it is presented.
- R2: A not-taken conditional branch gives `res_valid=1`, `res_taken=0` and `res_target = pc + 8`.
- R3: The compare-with-zero branches read the rs value as signed 32-bit. With opcode instr[31:26]=000001 and instr[20:16] selecting the condition, the codes are 00000 (less than zero), 00001 (greater or equal zero), 10000 (less than zero, linking) and 10001 (greater or equal zero, linking). Opcode 000110 is less-or-equal zero and opcode 000111 is greater than zero.
- R4: Opcode 000100 is taken when rs equals rt and opcode 000101 is taken when they differ, comparing all 32 bits.
- R5: Opcodes 000010 (jump) and 000011 (jump and link) are always taken, with target `{(pc+4)[31:28], instr[25:0], 2'b00}`.
- R6: The linking forms (the two linking codes under 000001, and opcode 000011) produce `wr_en=1`, `wr_addr=31` and `wr_data=pc+8` one cycle later, whether taken or not.
- R7: A link write wins over `ext_wr_en` in the same cycle. Otherwise the external write passes through registered, and `wr_addr` and `wr_data` read zero when no write is made.
- R8: Every valid branch or jump sets `in_delay_slot` from the next cycle. A valid non-branch instruction clears it, and cycles without `in_valid` leave it unchanged.
- R9: A valid branch presented while `in_delay_slot=1` raises `slot_err` for one cycle along with its own result, and the unit stays in the slot state.
- R10: While reset is low, all outputs are zero and the state is `ST_IDLE`.
- R11: Other opcodes, and other condition codes under opcode 000001, produce no result (`res_valid=0`, `res_target=0`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_pc | input | 32 | Address of the presented instruction |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of the rs register |
| in_rt_val | input | 32 | Value of the rt register |
| ext_wr_en | input | 1 | Other write port request |
| ext_wr_addr | input | 5 | Other write port register number |
| ext_wr_data | input | 32 | Other write port data |
| res_valid | output | 1 | A branch or jump was resolved |
| res_taken | output | 1 | The resolved branch is taken |
| res_target | output | 32 | Next fetch address |
| slot_err | output | 1 | Branch found in a delay slot |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | 5 | Register write number |
| wr_data | output | 32 | Register write data |
| in_delay_slot | output | 1 | State is `ST_SLOT` |

## Verification
Every result is due exactly one clock after the instruction is presented. This covers the result, target, error flag, write port and slot state. The driver task applies each instruction on a falling edge and queues the expected result for the rising edge that follows. The monitor pops one entry shortly after each rising edge, so each comparison lands in the cycle where the registered outputs change. Idle cycles are queued too, which checks that the state holds and that no result appears.

// File: rtl/brj_pkg.sv
package brj_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_LTZ,
        K_GEZ,
        K_LEZ,
        K_GTZ,
        K_EQ,
        K_NE,
        K_JMP
    } br_kind_e;

    typedef struct packed {
        br_kind_e kind;
        logic     link;
    } br_dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_SLOT
    } slot_state_e;

    localparam logic [5:0] OPC_REGIMM = 6'b000001;
    localparam logic [5:0] OPC_JUMP   = 6'b000010;
    localparam logic [5:0] OPC_JLINK  = 6'b000011;
    localparam logic [5:0] OPC_EQ     = 6'b000100;
    localparam logic [5:0] OPC_NE     = 6'b000101;
    localparam logic [5:0] OPC_LEZ    = 6'b000110;
    localparam logic [5:0] OPC_GTZ    = 6'b000111;

    localparam logic [4:0] RC_LTZ   = 5'b00000;
    localparam logic [4:0] RC_GEZ   = 5'b00001;
    localparam logic [4:0] RC_LTZ_L = 5'b10000;
    localparam logic [4:0] RC_GEZ_L = 5'b10001;

endpackage

// File: rtl/brj_decode.sv
module brj_decode
    import brj_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [4:0] cond_code,
    output br_dec_t    dec
);
    always_comb begin
        dec.kind = K_NONE;
        dec.link = 1'b0;
        case (opc)
            OPC_REGIMM: begin
                case (cond_code)
                    RC_LTZ:   dec.kind = K_LTZ;
                    RC_GEZ:   dec.kind = K_GEZ;
                    RC_LTZ_L: begin dec.kind = K_LTZ; dec.link = 1'b1; end
                    RC_GEZ_L: begin dec.kind = K_GEZ; dec.link = 1'b1; end
                    default:  dec.kind = K_NONE;
                endcase
            end
            OPC_JUMP:  dec.kind = K_JMP;
            OPC_JLINK: begin dec.kind = K_JMP; dec.link = 1'b1; end
            OPC_EQ:    dec.kind = K_EQ;
            OPC_NE:    dec.kind = K_NE;
            OPC_LEZ:   dec.kind = K_LEZ;
            OPC_GTZ:   dec.kind = K_GTZ;
            default:   dec.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/brj_cond.sv
module brj_cond
    import brj_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e          kind,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    output logic              taken
);
    logic neg;
    logic zero;
    logic same;

    assign neg  = src_a[XLEN-1];
    assign zero = (src_a == '0);
    assign same = (src_a == src_b);

    always_comb begin
        unique case (kind)
            K_LTZ:   taken = neg;
            K_GEZ:   taken = !neg;
            K_LEZ:   taken = neg || zero;
            K_GTZ:   taken = !neg && !zero;
            K_EQ:    taken = same;
            K_NE:    taken = !same;
            K_JMP:   taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/brj_target.sv
module brj_target
    import brj_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 26,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IDX_W-1:0] idx,
    input  br_kind_e         kind,
    input  logic             taken,
    output logic [XLEN-1:0]  target
);
    localparam int REGION_LSB = IDX_W + 2;
    localparam int EXT_W      = XLEN - IMM_W - 2;

    logic [XLEN-1:0] seq4;
    logic [XLEN-1:0] seq8;
    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] jmp_tgt;

    assign seq4    = pc + XLEN'(4);
    assign seq8    = pc + XLEN'(8);
    assign rel_off = {{EXT_W{idx[IMM_W-1]}}, idx[IMM_W-1:0], 2'b00};
    assign jmp_tgt = {seq4[XLEN-1:REGION_LSB], idx, 2'b00};

    always_comb begin
        if (kind == K_JMP)
            target = jmp_tgt;
        else if (taken)
            target = seq4 + rel_off;
        else
            target = seq8;
    end
endmodule

// File: rtl/brj_resolve_unit.sv
module brj_resolve_unit
    import brj_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RAW      = 5,
    parameter int LINK_REG = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_pc,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_rs_val,
    input  logic [XLEN-1:0] in_rt_val,
    input  logic            ext_wr_en,
    input  logic [RAW-1:0]  ext_wr_addr,
    input  logic [XLEN-1:0] ext_wr_data,
    output logic            res_valid,
    output logic            res_taken,
    output logic [XLEN-1:0] res_target,
    output logic            slot_err,
    output logic            wr_en,
    output logic [RAW-1:0]  wr_addr,
    output logic [XLEN-1:0] wr_data,
    output logic            in_delay_slot
);
    localparam int IDX_W = 26;
    localparam int IMM_W = 16;
    localparam logic [RAW-1:0] LINK_ADDR = RAW'(LINK_REG);

    br_dec_t         dec;
    logic            cond_taken;
    logic [XLEN-1:0] tgt;
    logic            is_br;
    logic            br_now;
    logic            link_now;
    slot_state_e     st_q;
    slot_state_e     st_d;

    brj_decode u_decode (
        .opc       (in_instr[31:26]),
        .cond_code (in_instr[20:16]),
        .dec       (dec)
    );

    brj_cond #(.XLEN(XLEN)) u_cond (
        .kind  (dec.kind),
        .src_a (in_rs_val),
        .src_b (in_rt_val),
        .taken (cond_taken)
    );

    brj_target #(.XLEN(XLEN), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_target (
        .pc     (in_pc),
        .idx    (in_instr[IDX_W-1:0]),
        .kind   (dec.kind),
        .taken  (cond_taken),
        .target (tgt)
    );

    assign is_br    = (dec.kind != K_NONE);
    assign br_now   = in_valid && is_br;
    assign link_now = br_now && dec.link;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (br_now) st_d = ST_SLOT;
            ST_SLOT: if (in_valid && !is_br) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign in_delay_slot = (st_q == ST_SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_taken  <= 1'b0;
            res_target <= '0;
            slot_err   <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            res_valid  <= br_now;
            res_taken  <= br_now && cond_taken;
            res_target <= br_now ? tgt : '0;
            slot_err   <= br_now && (st_q == ST_SLOT);
            if (link_now) begin
                wr_en   <= 1'b1;
                wr_addr <= LINK_ADDR;
                wr_data <= in_pc + XLEN'(8);
            end else if (ext_wr_en) begin
                wr_en   <= 1'b1;
                wr_addr <= ext_wr_addr;
                wr_data <= ext_wr_data;
            end else begin
                wr_en   <= 1'b0;
                wr_addr <= '0;
                wr_data <= '0;
            end
        end
    end

    // R9: an error is only ever reported together with a resolved branch
    a_r9_err_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> (res_valid && in_delay_slot));

    // R2: a not-taken result always points past the delay slot
    a_r2_not_taken_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> (res_target == $past(in_pc) + XLEN'(8)));

    // R8: a resolved branch always leaves the unit in the slot state
    a_r8_slot_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> in_delay_slot);

    // R6/R7: a link request owns the write port the next cycle
    a_r7_link_priority: assert property (@(posedge clk) disable iff (!rst_n)
        link_now |=> (wr_en && wr_addr == LINK_ADDR));

    // R11: no result without a valid instruction before it
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
endmodule

// File: tb/brj_resolve_unit_bench.sv
`timescale 1ns/1ps
module brj_resolve_unit_bench;

    typedef struct {
        logic        rv;
        logic        tk;
        logic [31:0] tg;
        logic        er;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        ds;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_rs_val = '0;
    logic [31:0] in_rt_val = '0;
    logic        ext_wr_en = 1'b0;
    logic [4:0]  ext_wr_addr = '0;
    logic [31:0] ext_wr_data = '0;
    logic        res_valid, res_taken, slot_err, wr_en, in_delay_slot;
    logic [31:0] res_target, wr_data;
    logic [4:0]  wr_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mdl_slot = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    brj_resolve_unit u_brj_resolve_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_instr(in_instr), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
        .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .slot_err(slot_err), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_delay_slot(in_delay_slot)
    );

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [15:0] imm);
        return {op, 5'd3, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] idx);
        return {op, idx};
    endfunction

    task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic ewe, input logic [4:0] ewa, input logic [31:0] ewd,
                        input string tag);
        exp_t e;
        logic [5:0] op;
        logic [4:0] rc;
        logic br, lk, tk;
        logic [31:0] pc4;
        @(negedge clk);
        in_valid = v; in_pc = pc; in_instr = ins; in_rs_val = a; in_rt_val = b;
        ext_wr_en = ewe; ext_wr_addr = ewa; ext_wr_data = ewd;
        op = ins[31:26]; rc = ins[20:16];
        br = 0; lk = 0; tk = 0;
        case (op)
            6'd1: begin
                if (rc == 5'd0 || rc == 5'd16) begin br = 1; tk = $signed(a) < 0; lk = rc[4]; end
                if (rc == 5'd1 || rc == 5'd17) begin br = 1; tk = $signed(a) >= 0; lk = rc[4]; end
            end
            6'd2: begin br = 1; tk = 1; end
            6'd3: begin br = 1; tk = 1; lk = 1; end
            6'd4: begin br = 1; tk = (a == b); end
            6'd5: begin br = 1; tk = (a != b); end
            6'd6: begin br = 1; tk = $signed(a) <= 0; end
            6'd7: begin br = 1; tk = $signed(a) > 0; end
            default: ;
        endcase
        br = br && v; lk = lk && br; tk = tk && br;
        pc4 = pc + 32'd4;
        e.rv = br; e.tk = tk; e.er = br && mdl_slot;
        if (!br) e.tg = '0;
        else if (op == 6'd2 || op == 6'd3) e.tg = {pc4[31:28], ins[25:0], 2'b00};
        else if (tk) e.tg = pc4 + {{14{ins[15]}}, ins[15:0], 2'b00};
        else e.tg = pc + 32'd8;
        if (lk) begin e.we = 1; e.wa = 5'd31; e.wd = pc + 32'd8; end
        else if (ewe) begin e.we = 1; e.wa = ewa; e.wd = ewd; end
        else begin e.we = 0; e.wa = '0; e.wd = '0; end
        if (br) mdl_slot = 1;
        else if (v) mdl_slot = 0;
        e.ds = mdl_slot;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic nop(input string tag);
        step(1, 32'h0000_2000, enc_i(6'b001001, 5'd4, 16'h0001), 0, 0, 0, 0, 0, tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (res_valid !== e.rv || res_taken !== e.tk || res_target !== e.tg ||
                slot_err !== e.er || wr_en !== e.we || wr_addr !== e.wa ||
                wr_data !== e.wd || in_delay_slot !== e.ds) begin
                failures++;
                $display("FAIL %s: got v%b t%b tg=%h e%b w%b a%0d d=%h s%b exp v%b t%b tg=%h e%b w%b a%0d d=%h s%b",
                    e.tag, res_valid, res_taken, res_target, slot_err, wr_en, wr_addr, wr_data, in_delay_slot,
                    e.rv, e.tk, e.tg, e.er, e.we, e.wa, e.wd, e.ds);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 0 || res_taken !== 0 || res_target !== 0 || slot_err !== 0 ||
            wr_en !== 0 || wr_addr !== 0 || wr_data !== 0 || in_delay_slot !== 0) begin
            failures++;
            $display("FAIL R10: got v%b tg=%h w%b s%b exp all zero", res_valid, res_target, wr_en, in_delay_slot);
        end
        rst_n = 1'b1;
        // R4 R1: equal, taken, negative offset
        step(1, 32'h0000_1000, enc_i(6'd4, 5'd5, 16'hFFFE), 32'h1234_5678, 32'h1234_5678, 0, 0, 0, "R4_R1 eq taken");
        nop("R8 clear");
        // R4 R2: differ only in bit 31
        step(1, 32'h0000_1100, enc_i(6'd4, 5'd5, 16'h0010), 32'h8000_0001, 32'h0000_0001, 0, 0, 0, "R4_R2 eq not taken");
        nop("R8 clear");
        step(1, 32'h0000_1200, enc_i(6'd5, 5'd5, 16'h0010), 32'h7, 32'h7, 0, 0, 0, "R4 ne not taken");
        nop("R8 clear");
        step(1, 32'h0000_1300, enc_i(6'd5, 5'd5, 16'h7FFF), 32'h7, 32'h6, 0, 0, 0, "R4_R1 ne taken max offset");
        nop("R8 clear");
        // R3 compare-with-zero boundaries
        step(1, 32'h0000_2000, enc_i(6'd1, 5'd0, 16'h0004), 32'h8000_0000, 0, 0, 0, 0, "R3 ltz taken");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd1, 5'd0, 16'h0004), 32'h0, 0, 0, 0, 0, "R3 ltz zero");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd1, 5'd1, 16'h0004), 32'h0, 0, 0, 0, 0, "R3 gez zero");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd1, 5'd1, 16'h0004), 32'hFFFF_FFFF, 0, 0, 0, 0, "R3 gez neg");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd6, 5'd0, 16'h8000), 32'h0, 0, 0, 0, 0, "R3 lez zero");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd6, 5'd0, 16'h8000), 32'h1, 0, 0, 0, 0, "R3 lez one");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd7, 5'd0, 16'h0002), 32'h1, 0, 0, 0, 0, "R3 gtz one");
        nop("R8 clear");
        step(1, 32'h0000_2000, enc_i(6'd7, 5'd0, 16'h0002), 32'h8000_0000, 0, 0, 0, 0, "R3 gtz min");
        nop("R8 clear");
        // R6 R7: link not taken while external write competes
        step(1, 32'h0000_3000, enc_i(6'd1, 5'd16, 16'h0008), 32'h5, 0, 1, 5'd9, 32'hDEAD_BEEF, "R6_R7 link not taken wins");
        step(1, 32'h0000_3004, enc_i(6'b001001, 5'd4, 16'h0), 0, 0, 1, 5'd9, 32'hDEAD_BEEF, "R7 ext passes");
        step(1, 32'h0000_3100, enc_i(6'd1, 5'd17, 16'h0008), 32'h5, 0, 0, 0, 0, "R6 link taken");
        nop("R8 clear");
        // R5 jumps, region boundary
        step(1, 32'hA000_0FFC, enc_j(6'd2, 26'h3FF_FFFF), 0, 0, 0, 0, 0, "R5 jump region");
        nop("R8 clear");
        step(1, 32'hFFFF_FFFC, enc_j(6'd3, 26'h000_1234), 0, 0, 1, 5'd2, 32'h1, "R5_R6 jal wrap");
        nop("R8 clear");
        // R11: not a branch
        step(1, 32'h0000_4000, enc_i(6'd1, 5'd2, 16'h0004), 32'h8000_0000, 0, 0, 0, 0, "R11 other cond code");
        step(1, 32'h0000_4004, enc_i(6'd8, 5'd2, 16'h0004), 0, 0, 0, 0, 0, "R11 other opcode");
        // R8 hold through bubble, R9 error
        step(1, 32'h0000_5000, enc_i(6'd4, 5'd5, 16'h0001), 1, 1, 0, 0, 0, "R8 enter slot");
        step(0, 32'h0, 32'h0, 0, 0, 0, 0, 0, "R8 bubble holds");
        step(1, 32'h0000_5004, enc_i(6'd5, 5'd5, 16'h0001), 1, 1, 0, 0, 0, "R9 branch in slot");
        nop("R8 clear after slot");
        step(0, 32'h0, 32'h0, 0, 0, 0, 0, 0, "R8 idle");
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule